// File: doc/BRIEF.md
# Serial-Programmed FIFO Almost-Flag Thresholds

This block holds the two thresholds behind a FIFO's almost-empty and almost-full warnings and turns them into flags. The almost-empty threshold counts words still stored, measured up from the empty end. The almost-full threshold counts free locations, measured down from the full end. Each threshold is as wide as the FIFO address.

Both thresholds sit in one bit-serial chain on a dedicated serial clock. Software can shift new values in on one enable and shift them back out for checking on another. A master reset loads both thresholds from one of four preset values picked by two select pins. A partial reset clears the flags and keeps the thresholds.

The almost-empty flag is registered on the read clock from the occupancy seen by the read side. The almost-full flag is registered on the write clock from the occupancy seen by the write side. Both flags are active low. The serial pins are plain control pins with no handshake: a bit is taken or given on every rising serial clock edge while its enable is high.

Top module: `almost_flag_thresholds`

## Requirements
- R1: While `mrst` is high at a rising `ser_clk` edge, both thresholds are loaded with the preset picked by `dflt_sel`: code 0 gives 7, 1 gives 15, 2 gives 31 and 3 gives 63.
- R2: While `ser_load` is high, each rising `ser_clk` edge shifts one bit of `ser_in` into the chain. The almost-empty threshold goes in first, then the almost-full threshold, each least significant bit first, so a full load takes 2*AW edges.
- R3: While `ser_read` is high and `ser_load` is low, `ser_out` shows the current chain bit and each rising `ser_clk` edge advances to the next bit. The almost-empty threshold comes out first, then the almost-full threshold, each least significant bit first. After 2*AW edges the chain holds its original contents again.
- R4: When `ser_load` and `ser_read` are both high, loading wins. The bits shifted in become the new thresholds.
- R5: A partial reset (`prst`) leaves both thresholds unchanged. It forces the flags to their reset state: `ae_n` low and `af_n` high.
- R6: On each rising `rd_clk` edge outside reset, `ae_n` becomes 0 if `rd_level` is at or below the almost-empty threshold, and 1 otherwise.
- R7: On each rising `wr_clk` edge outside reset, `af_n` becomes 0 if DEPTH minus `wr_level` is at or below the almost-full threshold, and 1 otherwise.
- R8: While `mrst` is high, the flags are held at `ae_n` = 0 and `af_n` = 1.
- R9: With neither serial enable high and no master reset, the thresholds keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial programming clock |
| rd_clk | input | 1 | Read-side clock for the almost-empty flag |
| wr_clk | input | 1 | Write-side clock for the almost-full flag |
| mrst | input | 1 | Master reset, active high, synchronous in each domain |
| prst | input | 1 | Partial reset, active high; clears the flags only |
| dflt_sel | input | 2 | Selects the preset thresholds during master reset |
| ser_load | input | 1 | Serial load enable |
| ser_read | input | 1 | Serial readback enable |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out, the current chain bit |
| rd_level | input | AW+1 | Stored word count as seen by the read side |
| wr_level | input | AW+1 | Stored word count as seen by the write side |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
Serial load and serial readback can be requested on the same serial clock edge. The bench raises both enables together while it shifts in a new threshold pair. It then reads the chain back with the load enable low, and passes only if the new pair comes back. A partial reset falling between programming and readback is also applied. The bench judges it by the flag values and by a readback that matches the pair programmed earlier.

// File: rtl/aft_pkg.sv
package aft_pkg;
  // Preset threshold for a 2-bit select code: 7, 15, 31, 63
  function automatic int unsigned preset_thresh(input logic [1:0] code);
    return (32'd8 << code) - 32'd1;
  endfunction
endpackage

// File: rtl/aft_chain.sv
module aft_chain import aft_pkg::*; #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic [1:0]    dflt_sel,
  input  logic          ser_load,
  input  logic          ser_read,
  input  logic          ser_in,
  output logic          ser_out,
  output logic [AW-1:0] ae_thresh,
  output logic [AW-1:0] af_thresh
);
  localparam int CW = 2 * AW;

  logic [CW-1:0] chain;
  logic [AW-1:0] preset;
  logic          primed;

  assign preset = AW'(preset_thresh(dflt_sel));

  // Bit 0 is the next bit out: low half is almost-empty, high half almost-full
  always_ff @(posedge clk) begin
    if (mrst)          chain <= {preset, preset};
    else if (ser_load) chain <= {ser_in, chain[CW-1:1]};
    else if (ser_read) chain <= {chain[0], chain[CW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (mrst) primed <= 1'b1;
  end

  assign ser_out   = chain[0];
  assign ae_thresh = chain[AW-1:0];
  assign af_thresh = chain[CW-1:AW];

  // R1
  preset_chk: assert property (@(posedge clk) mrst |=> ae_thresh == af_thresh);
  // R2
  load_bit_chk: assert property (@(posedge clk) disable iff (mrst)
    (primed && ser_load) |=> chain[CW-1] == $past(ser_in));
  // R3
  rotate_keep_chk: assert property (@(posedge clk) disable iff (mrst)
    (primed && ser_read && !ser_load) |=> $countones(chain) == $past($countones(chain)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (mrst)
    (primed && !ser_load && !ser_read) |=> $stable(chain));
endmodule

// File: rtl/aft_flag.sv
module aft_flag #(
  parameter int   AW      = 7,
  parameter logic RST_VAL = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW:0]   amount,
  input  logic [AW-1:0] thresh,
  output logic          flag_n
);
  logic at_or_below;

  assign at_or_below = amount <= {1'b0, thresh};

  always_ff @(posedge clk) begin
    if (rst) flag_n <= RST_VAL;
    else     flag_n <= !at_or_below;
  end

  // R5
  rst_val_chk: assert property (@(posedge clk) rst |=> flag_n == RST_VAL);
  // R6
  thresh_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (amount == 0) |=> !flag_n);
endmodule

// File: rtl/almost_flag_thresholds.sv
module almost_flag_thresholds #(
  parameter int AW = 7
) (
  input  logic        ser_clk,
  input  logic        rd_clk,
  input  logic        wr_clk,
  input  logic        mrst,
  input  logic        prst,
  input  logic [1:0]  dflt_sel,
  input  logic        ser_load,
  input  logic        ser_read,
  input  logic        ser_in,
  output logic        ser_out,
  input  logic [AW:0] rd_level,
  input  logic [AW:0] wr_level,
  output logic        ae_n,
  output logic        af_n
);
  localparam int        DEPTH   = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [AW-1:0] ae_thresh, af_thresh;
  logic [AW:0]   free_slots;
  logic          flag_rst;

  assign flag_rst   = mrst | prst;
  assign free_slots = DEPTH_V - wr_level;

  aft_chain #(.AW(AW)) u_chain (
    .clk(ser_clk), .mrst(mrst), .dflt_sel(dflt_sel),
    .ser_load(ser_load), .ser_read(ser_read), .ser_in(ser_in),
    .ser_out(ser_out), .ae_thresh(ae_thresh), .af_thresh(af_thresh)
  );

  aft_flag #(.AW(AW), .RST_VAL(1'b0)) u_ae (
    .clk(rd_clk), .rst(flag_rst), .amount(rd_level),
    .thresh(ae_thresh), .flag_n(ae_n)
  );

  aft_flag #(.AW(AW), .RST_VAL(1'b1)) u_af (
    .clk(wr_clk), .rst(flag_rst), .amount(free_slots),
    .thresh(af_thresh), .flag_n(af_n)
  );

  // R8
  mrst_flags_chk: assert property (@(posedge rd_clk) mrst |=> !ae_n);
  // R7
  full_af_chk: assert property (@(posedge wr_clk) disable iff (flag_rst)
    (wr_level == DEPTH_V) |=> !af_n);
endmodule

// File: tb/test_almost_flag_thresholds.sv
module test_almost_flag_thresholds;
  localparam int AW = 7;
  localparam int CW = 2 * AW;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  always #5 clk = ~clk;

  logic mrst, prst, ser_load, ser_read, ser_in, ser_out, ae_n, af_n;
  logic [1:0] dflt_sel;
  logic [AW:0] rd_level, wr_level;
  int vecs = 0, bad = 0;

  almost_flag_thresholds #(.AW(AW)) i_almost_flag_thresholds (
    .ser_clk(clk), .rd_clk(clk), .wr_clk(clk), .mrst(mrst), .prst(prst),
    .dflt_sel(dflt_sel), .ser_load(ser_load), .ser_read(ser_read),
    .ser_in(ser_in), .ser_out(ser_out), .rd_level(rd_level),
    .wr_level(wr_level), .ae_n(ae_n), .af_n(af_n)
  );

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_mrst(input logic [1:0] s);
    @(negedge clk); mrst = 1; dflt_sel = s; rd_level = 100; wr_level = 0;
    @(posedge clk); @(negedge clk);
    check("R8 ae_n in reset", ae_n, 0);
    check("R8 af_n in reset", af_n, 1);
    mrst = 0;
  endtask

  task automatic load_pair(input int ae, input int af, input logic both);
    logic [CW-1:0] v = {af[AW-1:0], ae[AW-1:0]};
    for (int i = 0; i < CW; i++) begin
      @(negedge clk); ser_load = 1; ser_read = both; ser_in = v[i];
      @(posedge clk);
    end
    @(negedge clk); ser_load = 0; ser_read = 0;
  endtask

  task automatic read_pair(input string req, input int ae, input int af);
    logic [CW-1:0] v;
    for (int i = 0; i < CW; i++) begin
      @(negedge clk); ser_read = 1; #1 v[i] = ser_out;
      @(posedge clk);
    end
    @(negedge clk); ser_read = 0;
    check({req, " ae thresh"}, int'(v[AW-1:0]), ae);
    check({req, " af thresh"}, int'(v[CW-1:AW]), af);
  endtask

  task automatic sweep(input int ae, input int af);
    for (int l = 0; l <= DEPTH; l++) begin
      @(negedge clk); rd_level = l[AW:0]; wr_level = l[AW:0];
      @(posedge clk); @(negedge clk);
      check("R6 ae_n", ae_n, (l <= ae) ? 0 : 1);
      check("R7 af_n", af_n, ((DEPTH - l) <= af) ? 0 : 1);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    mrst = 1; prst = 0; dflt_sel = 0; ser_load = 0; ser_read = 0; ser_in = 0;
    rd_level = 0; wr_level = 0;
    for (int s = 0; s < 4; s++) begin
      do_mrst(s[1:0]);
      read_pair("R1 preset", (8 << s) - 1, (8 << s) - 1);
      read_pair("R3 restore after readback", (8 << s) - 1, (8 << s) - 1);
    end
    sweep(63, 63);
    // R2: several serial patterns, then R9 idle hold
    load_pair(5, 9, 0);
    repeat (5) @(negedge clk);
    read_pair("R2 R9 load 5/9", 5, 9);
    sweep(5, 9);
    load_pair(0, 127, 0);
    read_pair("R2 load 0/127", 0, 127);
    sweep(0, 127);
    load_pair(127, 0, 0);
    read_pair("R2 load 127/0", 127, 0);
    sweep(127, 0);
    // R4: load and readback together
    load_pair(42, 85, 1);
    read_pair("R4 load wins", 42, 85);
    // R5: partial reset keeps thresholds, resets flags
    @(negedge clk); rd_level = 100; wr_level = 0;
    @(posedge clk); @(negedge clk);
    check("R6 ae_n high before prst", ae_n, 1);
    prst = 1; wr_level = DEPTH[AW:0];
    @(posedge clk); @(negedge clk);
    check("R5 ae_n after prst", ae_n, 0);
    check("R5 af_n after prst", af_n, 1);
    prst = 0;
    read_pair("R5 thresholds kept", 42, 85);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule